// File: doc/BRIEF.md
# DRAM Address Override Driver

This block holds two byte-wide registers that let software take over a DRAM address bus and bank-address pair for mode-register loading. The memory controller cannot generate every bit pattern needed during initialization. Software therefore writes the wanted levels into the registers and then sets an enable bit. While that bit is set, the block drives the address and bank pins from the register contents and opens the isolation switches that normally join the controller to those lines. While the bit is clear, the pad drivers are off and the switches pass the controller's own signals.

Access comes through a decoded host port: one write strobe and one read strobe, an address and a data byte. The serial transport layer is not part of the block. After reset the block stays silent until the memory clock-enable input has been seen high once. Until then it accepts no writes and reads as zero. The register pair sits at one of two base addresses, chosen by a parameter.

Top module: `addr_override_drv`

## Requirements
- R1: After reset both registers hold 00h. The pad enable `dram_oe_o` is 0, the switch enable `pass_sw_en_o` is 1, and `dram_a_o` and `dram_ba_o` are 0.
- R2: Bit n of the low register (offset 0) drives `dram_a_o[n]` for n = 0 to 7.
- R3: In the high register (offset 1), bits 4:0 drive `dram_a_o[12:8]` and bits 6:5 drive `dram_ba_o[1:0]`.
- R4: Bit 7 of the high register is the override enable. When it is 1, `dram_oe_o` is 1 and `pass_sw_en_o` is 0. When it is 0, `dram_oe_o` is 0, `pass_sw_en_o` is 1, and `dram_a_o` and `dram_ba_o` read 0.
- R5: A write shows on the pins at the clock edge that stores it, with no further commit. The pins still show the old value during the write cycle itself.
- R6: The low register answers at BASE and the high register at BASE+1. BASE is 0080h when `BASE_SEL`=0 and AC10h when `BASE_SEL`=1.
- R7: A read returns the value last written to that register. A read in the same cycle as a write to that register returns the old value.
- R8: A write to any address other than BASE or BASE+1 changes nothing. A read of such an address returns 00h.
- R9: From reset until `cke_i` has been sampled high at a clock edge, writes are dropped and reads return 00h. This includes a write in the very cycle in which `cke_i` is first high.
- R10: Once `cke_i` has been seen high, the host port stays enabled even if `cke_i` falls again, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Memory clock enable; its first high level wakes the host port |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe |
| host_addr_i | input | 16 | Register address |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data, combinational with the read strobe |
| dram_a_o | output | 13 | Address pattern driven when overriding |
| dram_ba_o | output | 2 | Bank-address pattern driven when overriding |
| dram_oe_o | output | 1 | Pad output enable; 0 means high impedance |
| pass_sw_en_o | output | 1 | Isolation switch enable; 1 passes the controller's lines |

## Verification
Two pairs of events can land in the same cycle. The first is the wake-up edge of `cke_i` meeting a host write. The bench raises `cke_i` and a write strobe together in one cycle, then reads the register back and expects 00h. A repeat of the write must then stick. The second is a read and a write to the same register in one cycle. The bench issues both strobes together and expects the read to return the old byte, while the pins show the new byte only after the storing edge.

// File: rtl/addr_ovr_pkg.sv
`timescale 1ns/1ps
package addr_ovr_pkg;
   localparam int REG_W  = 8;
   localparam int A_W    = 13;
   localparam int BA_W   = 2;
   localparam int AHI_W  = A_W - REG_W;

   typedef struct packed {
      logic             en;
      logic [BA_W-1:0]  ba;
      logic [AHI_W-1:0] a_hi;
   } ctl_reg_t;
endpackage

// File: rtl/ovr_decode.sv
`timescale 1ns/1ps
module ovr_decode #(
   parameter int ADDR_W   = 16,
   parameter int BASE_SEL = 0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              sel_lo_o,
   output logic              sel_hi_o
);
   generate
      if (BASE_SEL == 0) begin : g_base_low
         localparam logic [ADDR_W-1:0] BASE = ADDR_W'(16'h0080);
         assign sel_lo_o = (addr_i == BASE);
         assign sel_hi_o = (addr_i == BASE + ADDR_W'(1));
      end else if (BASE_SEL == 1) begin : g_base_high
         if (ADDR_W < 16) begin : g_bad_width
            $error("ovr_decode: ADDR_W too small for base AC10h");
         end
         localparam logic [ADDR_W-1:0] BASE = ADDR_W'(16'hAC10);
         assign sel_lo_o = (addr_i == BASE);
         assign sel_hi_o = (addr_i == BASE + ADDR_W'(1));
      end else begin : g_bad_sel
         $error("ovr_decode: BASE_SEL must be 0 or 1");
         assign sel_lo_o = 1'b0;
         assign sel_hi_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ovr_wake.sv
`timescale 1ns/1ps
module ovr_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic cke_i,
   output logic live_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     live_o <= 1'b0;
      else if (cke_i) live_o <= 1'b1;
   end

   // R10: once awake, the port stays awake until reset
   assert_stay_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      live_o |=> live_o);
endmodule

// File: rtl/ovr_regfile.sv
`timescale 1ns/1ps
module ovr_regfile
   import addr_ovr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live_i,
   input  logic             wr_i,
   input  logic             rd_i,
   input  logic             sel_lo_i,
   input  logic             sel_hi_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] reg_lo_o,
   output ctl_reg_t         reg_hi_o,
   output logic [REG_W-1:0] rdata_o
);
   logic wr_ok;
   assign wr_ok = live_i && wr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_lo_o <= '0;
         reg_hi_o <= '0;
      end else begin
         if (wr_ok && sel_lo_i) reg_lo_o <= wdata_i;
         if (wr_ok && sel_hi_i) reg_hi_o <= ctl_reg_t'(wdata_i);
      end
   end

   always_comb begin
      rdata_o = '0;
      if (live_i && rd_i) begin
         if (sel_lo_i)      rdata_o = reg_lo_o;
         else if (sel_hi_i) rdata_o = reg_hi_o;
      end
   end

   // R9: nothing is stored while the port is asleep
   assert_asleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !live_i |=> ($stable(reg_lo_o) && $stable(reg_hi_o)));

   // R8: a write that decodes to neither register changes nothing
   assert_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !sel_lo_i && !sel_hi_i) |=> ($stable(reg_lo_o) && $stable(reg_hi_o)));

   // R7: an accepted write to the low register is what it holds next
   assert_store_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (live_i && wr_i && sel_lo_i) |=> (reg_lo_o == $past(wdata_i)));
endmodule

// File: rtl/ovr_pinmap.sv
`timescale 1ns/1ps
module ovr_pinmap
   import addr_ovr_pkg::*;
(
   input  logic [REG_W-1:0] reg_lo_i,
   input  ctl_reg_t         reg_hi_i,
   output logic [A_W-1:0]   a_o,
   output logic [BA_W-1:0]  ba_o,
   output logic             oe_o,
   output logic             sw_en_o
);
   assign oe_o    = reg_hi_i.en;
   assign sw_en_o = ~reg_hi_i.en;

   genvar i;
   generate
      for (i = 0; i < A_W; i++) begin : g_abit
         if (i < REG_W) begin : g_from_lo
            assign a_o[i] = reg_hi_i.en & reg_lo_i[i];
         end else begin : g_from_hi
            assign a_o[i] = reg_hi_i.en & reg_hi_i.a_hi[i-REG_W];
         end
      end
      for (i = 0; i < BA_W; i++) begin : g_babit
         assign ba_o[i] = reg_hi_i.en & reg_hi_i.ba[i];
      end
   endgenerate
endmodule

// File: rtl/addr_override_drv.sv
`timescale 1ns/1ps
module addr_override_drv
   import addr_ovr_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int BASE_SEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_i,
   input  logic              host_wr_i,
   input  logic              host_rd_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic [7:0]        host_wdata_i,
   output logic [7:0]        host_rdata_o,
   output logic [12:0]       dram_a_o,
   output logic [1:0]        dram_ba_o,
   output logic              dram_oe_o,
   output logic              pass_sw_en_o
);
   logic     live, sel_lo, sel_hi;
   logic [REG_W-1:0] reg_lo;
   ctl_reg_t reg_hi;

   ovr_decode #(.ADDR_W(ADDR_W), .BASE_SEL(BASE_SEL)) u_dec (
      .addr_i(host_addr_i), .sel_lo_o(sel_lo), .sel_hi_o(sel_hi));

   ovr_wake u_wake (.clk(clk), .rst_n(rst_n), .cke_i(cke_i), .live_o(live));

   ovr_regfile u_regs (
      .clk(clk), .rst_n(rst_n), .live_i(live), .wr_i(host_wr_i), .rd_i(host_rd_i),
      .sel_lo_i(sel_lo), .sel_hi_i(sel_hi), .wdata_i(host_wdata_i),
      .reg_lo_o(reg_lo), .reg_hi_o(reg_hi), .rdata_o(host_rdata_o));

   ovr_pinmap u_pins (
      .reg_lo_i(reg_lo), .reg_hi_i(reg_hi), .a_o(dram_a_o), .ba_o(dram_ba_o),
      .oe_o(dram_oe_o), .sw_en_o(pass_sw_en_o));

   // R4/R5: an accepted write setting the enable bit takes the pins at the storing edge
   assert_enable_takes_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (live && host_wr_i && sel_hi && host_wdata_i[7]) |=> (dram_oe_o && !pass_sw_en_o));

   // R5: the address pins follow an accepted low-register write at once
   assert_immediate_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (live && host_wr_i && sel_lo && reg_hi.en && !sel_hi) |=> (dram_a_o[7:0] == $past(host_wdata_i)));
endmodule

// File: tb/addr_override_drv_tb_top.sv
`timescale 1ns/1ps
module addr_override_drv_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] BASE = 16'h0080;

   logic clk = 1'b0, rst_n = 1'b0, cke = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0, rdata;
   logic [12:0] pa;
   logic [1:0]  pba;
   logic        poe, psw;
   int n_chk = 0, n_fail = 0;
   logic [7:0] m_lo = 8'h00, m_hi = 8'h00;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_override_drv dut_i (
      .clk(clk), .rst_n(rst_n), .cke_i(cke), .host_wr_i(wr), .host_rd_i(rd),
      .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
      .dram_a_o(pa), .dram_ba_o(pba), .dram_oe_o(poe), .pass_sw_en_o(psw));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_pins(input string req);
      logic en;
      en = m_hi[7];
      chk(req, {15'd0, poe}, {15'd0, en});
      chk(req, {15'd0, psw}, {15'd0, ~en});
      chk(req, {3'd0, pa}, en ? {3'd0, m_hi[4:0], m_lo} : 16'h0);
      chk(req, {14'd0, pba}, en ? {14'd0, m_hi[6:5]} : 16'h0);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic do_read(input string req, input logic [15:0] a, input logic [7:0] exp);
      @(negedge clk); rd = 1'b1; addr = a;
      #1 chk(req, {8'd0, rdata}, {8'd0, exp});
      rd = 1'b0;
   endtask

   task automatic apply_reset();
      rst_n = 1'b0; cke = 1'b0; wr = 1'b0; rd = 1'b0;
      m_lo = 8'h00; m_hi = 8'h00;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      apply_reset();
      chk_pins("R1");
      do_read("R1", BASE, 8'h00);
      do_read("R1", BASE + 16'd1, 8'h00);
   endtask

   task automatic t_asleep();
      do_write(BASE, 8'h55);
      do_write(BASE + 16'd1, 8'h9F);
      do_read("R9", BASE, 8'h00);
      chk_pins("R9");
      @(negedge clk); cke = 1'b1;
      @(negedge clk); cke = 1'b0;
      do_read("R10", BASE, 8'h00);
   endtask

   task automatic t_field_map();
      do_write(BASE, 8'hA5);          m_lo = 8'hA5;
      do_write(BASE + 16'd1, 8'hD6);  m_hi = 8'hD6;
      chk_pins("R2");
      chk_pins("R3");
      do_read("R7", BASE, 8'hA5);
      do_read("R6", BASE + 16'd1, 8'hD6);
      do_write(BASE + 16'd1, 8'hAB);  m_hi = 8'hAB;
      do_write(BASE, 8'h3C);          m_lo = 8'h3C;
      chk_pins("R3");
      chk_pins("R10");
   endtask

   task automatic t_write_timing();
      @(negedge clk); wr = 1'b1; rd = 1'b1; addr = BASE; wdata = 8'h81;
      #1 chk("R5", {3'd0, pa}, {3'd0, m_hi[4:0], m_lo});
      chk("R7", {8'd0, rdata}, {8'd0, m_lo});
      m_lo = 8'h81;
      @(negedge clk); wr = 1'b0; rd = 1'b0;
      chk_pins("R5");
   endtask

   task automatic t_disable();
      do_write(BASE + 16'd1, 8'h7F);  m_hi = 8'h7F;
      chk_pins("R4");
      do_read("R4", BASE + 16'd1, 8'h7F);
      do_write(BASE + 16'd1, 8'h80);  m_hi = 8'h80;
      chk_pins("R4");
   endtask

   task automatic t_stray();
      do_write(BASE + 16'd2, 8'hFF);
      do_write(BASE - 16'd1, 8'hFF);
      do_write(16'hAC10, 8'hFF);
      chk_pins("R8");
      do_read("R8", BASE + 16'd2, 8'h00);
      do_read("R8", 16'hAC11, 8'h00);
      do_read("R8", BASE, m_lo);
   endtask

   task automatic t_wake_collision();
      apply_reset();
      @(negedge clk); cke = 1'b1; wr = 1'b1; addr = BASE; wdata = 8'h3C;
      @(negedge clk); wr = 1'b0;
      do_read("R9", BASE, 8'h00);
      do_write(BASE, 8'h3C); m_lo = 8'h3C;
      do_read("R9", BASE, 8'h3C);
   endtask

   initial begin
      t_reset_state();
      t_asleep();
      t_field_map();
      t_write_timing();
      t_disable();
      t_stray();
      t_wake_collision();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule